// File: doc/BRIEF.md
# Masked frame scrubber for configuration memory

This block sweeps a configuration memory frame by frame, looking for upset bits. For each frame it asks for the shared configuration port and waits for the grant. It then reads the frame back word by word. In the same cycles it fetches the matching words of the known-good image and of a mask of functionally significant bits. A difference on a masked bit makes the block rewrite the whole frame from a local copy of the good data. A difference that lies only on unmasked bits is counted and otherwise left alone. The port is released between frames so that other users of the configuration port can get in.

A sweep starts on a one-cycle `start` pulse. If `refresh` is high with that pulse, the sweep changes role. After a partial reconfiguration the stored good image no longer matches the memory. In this mode the block copies every word it reads back into the good-image store. It compares nothing and writes nothing to the configuration memory. Later sweeps therefore raise no false alarms. The sweep ends with a one-cycle `pass_done` pulse. Both counters hold their values until the next sweep begins.

Top module: `frame_scrubber`

## Requirements
- R1: Synchronous reset: while `rst_n` is low, at the next clock edge `busy`, `pass_done`, `cfg_req`, `cfg_rd_en`, `cfg_wr_en`, `gold_wr_en`, both counters and `scan_frame` go to 0.
- R2: A sweep reads frames 0 to NUM_FRAMES-1 in ascending order. Within each frame it reads words 0 to FRAME_WORDS-1 in ascending order, one per cycle. Read data and the good/mask data for an address are taken one cycle after the address is given.
- R3: A frame with at least one bit where (readback XOR good) AND mask is 1 is rewritten in full with the good data. `corr_count` then rises by one.
- R4: A frame whose differences all lie on bits with mask 0 is not written. `benign_count` then rises by one.
- R5: A frame whose readback equals its good data causes no write and changes no counter.
- R6: `cfg_req` stays high from the request until the frame is finished, and it drops for at least one cycle between frames. No configuration read or write is issued unless `cfg_gnt` is high.
- R7: With the grant returned one cycle after the request, a sweep takes 4 + FRAME_WORDS cycles per frame, plus another FRAME_WORDS cycles for each rewritten frame. This is counted from the edge that accepts `start` to the cycle in which `pass_done` is high.
- R8: `pass_done` is high for exactly one cycle at the end of a sweep. `busy` is low in the cycle after it.
- R9: In a refresh sweep each word read back is written to the good-image store at the same frame and word. There are no configuration writes and both counters stay 0. A normal sweep that follows it finds no differences.
- R10: `start` and `refresh` are ignored while `busy` is high.
- R11: Both counters clear when a sweep starts. They saturate at 2^CNT_W-1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a sweep (pulse, ignored while busy) |
| refresh | input | 1 | With start: sweep copies readback into the good-image store |
| cfg_req | output | 1 | Request for the configuration port |
| cfg_gnt | input | 1 | Grant of the configuration port |
| scan_frame | output | $clog2(NUM_FRAMES) | Current frame address for all three stores |
| cfg_word | output | $clog2(FRAME_WORDS) | Word address for configuration read/write and good/mask read |
| cfg_rd_en | output | 1 | Configuration read strobe |
| cfg_rd_data | input | WORD_W | Configuration readback, one cycle after the strobe |
| cfg_wr_en | output | 1 | Configuration write strobe |
| cfg_wr_data | output | WORD_W | Configuration write data |
| gold_rd_en | output | 1 | Good-image and mask read strobe |
| gold_rd_data | input | WORD_W | Good-image word, one cycle after the strobe |
| mask_rd_data | input | WORD_W | Mask word (1 = significant), one cycle after the strobe |
| gold_wr_en | output | 1 | Good-image write strobe (refresh sweeps) |
| gold_wr_word | output | $clog2(FRAME_WORDS) | Good-image write word address |
| gold_wr_data | output | WORD_W | Good-image write data |
| corr_count | output | CNT_W | Frames rewritten in this sweep |
| benign_count | output | CNT_W | Frames with only non-significant differences |
| busy | output | 1 | Sweep in progress |
| pass_done | output | 1 | One-cycle end-of-sweep pulse |

## Verification
Readback, good and mask data come back one clock after the address. The grant comes back one clock after the request. A sweep therefore ends exactly 4 + FRAME_WORDS (+ FRAME_WORDS when a frame is rewritten) edges per frame after `start` is accepted. The bench counts falling edges from that point and checks the count and the `pass_done` pulse against this sum. Counters, memory images, write counts and request drops are checked in the falling-edge cycle after `pass_done`, when every write has landed. Address order and grant use are checked at each falling edge while the sweep runs.

// File: rtl/scrub_pkg.sv
// Shared types of the frame scrubber.
// Assumes: nothing beyond IEEE 1800-2017.
package scrub_pkg;

    // Sweep sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_READ  = 3'd2,
        ST_CMP   = 3'd3,
        ST_WRITE = 3'd4,
        ST_NEXT  = 3'd5,
        ST_DONE  = 3'd6
    } scrub_state_t;

endpackage

// File: rtl/scrub_frame_buf.sv
// One-frame store of good data, filled during readback and replayed on rewrite.
// Assumes: write and read addresses stay below FRAME_WORDS; read is combinational.
module scrub_frame_buf #(
    parameter int WORD_W      = 32,
    parameter int FRAME_WORDS = 93,
    localparam int WI_W       = $clog2(FRAME_WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [WI_W-1:0]   waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WI_W-1:0]   raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem [FRAME_WORDS];

    // Capture one good word per valid readback cycle.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Replay port used while the frame is rewritten.
    assign rdata = mem[raddr];

endmodule

// File: rtl/scrub_cmp.sv
// Streaming word compare: flags masked and unmasked differences over a frame,
// and steers returned data to the frame buffer or, on refresh, the good store.
// Assumes: read data arrives one cycle after rd_fire; clear precedes each frame.
module scrub_cmp #(
    parameter int WORD_W      = 32,
    parameter int FRAME_WORDS = 93,
    parameter int LANE_W      = 8,
    localparam int WI_W       = $clog2(FRAME_WORDS),
    localparam int LANES      = WORD_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              refresh_mode,
    input  logic              rd_fire,
    input  logic [WI_W-1:0]   rd_word,
    input  logic [WORD_W-1:0] cfg_rd_data,
    input  logic [WORD_W-1:0] gold_rd_data,
    input  logic [WORD_W-1:0] mask_rd_data,
    output logic              ess_any,
    output logic              ben_any,
    output logic              buf_we,
    output logic [WI_W-1:0]   buf_waddr,
    output logic [WORD_W-1:0] buf_wdata,
    output logic              gold_wr_en,
    output logic [WI_W-1:0]   gold_wr_word,
    output logic [WORD_W-1:0] gold_wr_data
);

    logic              v_q;
    logic [WI_W-1:0]   w_q;
    logic              ess_acc, ben_acc;
    logic [WORD_W-1:0] diff;
    logic [LANES-1:0]  lane_ess, lane_ben;
    logic              word_ess, word_ben, cmp_live;

    assign diff     = cfg_rd_data ^ gold_rd_data;
    assign cmp_live = v_q & ~refresh_mode;

    // Per-lane reduction keeps the OR trees short.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_ess[i] = |(diff[i*LANE_W +: LANE_W] &  mask_rd_data[i*LANE_W +: LANE_W]);
        assign lane_ben[i] = |(diff[i*LANE_W +: LANE_W] & ~mask_rd_data[i*LANE_W +: LANE_W]);
    end

    assign word_ess = |lane_ess;
    assign word_ben = |lane_ben;

    // Align the word address with the data returned one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= 1'b0;
            w_q <= '0;
        end else begin
            v_q <= rd_fire;
            w_q <= rd_word;
        end
    end

    // Accumulate difference flags across the words of one frame.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ess_acc <= 1'b0;
            ben_acc <= 1'b0;
        end else if (cmp_live) begin
            ess_acc <= ess_acc | word_ess;
            ben_acc <= ben_acc | word_ben;
        end
    end

    // Frame verdicts include the word arriving in the current cycle.
    assign ess_any = ess_acc | (cmp_live & word_ess);
    assign ben_any = ben_acc | (cmp_live & word_ben);

    assign buf_we       = cmp_live;
    assign buf_waddr    = w_q;
    assign buf_wdata    = gold_rd_data;
    assign gold_wr_en   = v_q & refresh_mode;
    assign gold_wr_word = w_q;
    assign gold_wr_data = cfg_rd_data;

    // R2: consecutive reads of a frame step the word address by one.
    assert_word_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q && rd_fire) |-> (rd_word == w_q + 1'b1));

endmodule

// File: rtl/scrub_ctrl.sv
// Sweep sequencer: port request, read/compare/rewrite per frame, counters.
// Assumes: grant is held by the arbiter while cfg_req stays high.
module scrub_ctrl
    import scrub_pkg::*;
#(
    parameter int NUM_FRAMES  = 8,
    parameter int FRAME_WORDS = 93,
    parameter int CNT_W       = 16,
    localparam int FA_W       = $clog2(NUM_FRAMES),
    localparam int WI_W       = $clog2(FRAME_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             refresh,
    input  logic             cfg_gnt,
    input  logic             ess_any,
    input  logic             ben_any,
    output logic             cfg_req,
    output logic [FA_W-1:0]  frame,
    output logic [WI_W-1:0]  widx,
    output logic             rd_en,
    output logic             wr_en,
    output logic             gold_rd_en,
    output logic             refresh_mode,
    output logic             clear,
    output logic [CNT_W-1:0] corr_count,
    output logic [CNT_W-1:0] benign_count,
    output logic             busy,
    output logic             pass_done
);

    localparam logic [WI_W-1:0]  LAST_WORD  = WI_W'(FRAME_WORDS - 1);
    localparam logic [FA_W-1:0]  LAST_FRAME = FA_W'(NUM_FRAMES - 1);
    localparam logic [CNT_W-1:0] CNT_MAX    = '1;

    scrub_state_t state;
    logic         accept, bump_corr, bump_ben;

    assign accept    = (state == ST_IDLE) && start;
    assign bump_corr = (state == ST_CMP) && !refresh_mode && ess_any;
    assign bump_ben  = (state == ST_CMP) && !refresh_mode && !ess_any && ben_any;

    // State, frame and word sequencing of one sweep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            frame        <= '0;
            widx         <= '0;
            refresh_mode <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state        <= ST_REQ;
                    frame        <= '0;
                    refresh_mode <= refresh;
                end
                ST_REQ: if (cfg_gnt) begin
                    state <= ST_READ;
                    widx  <= '0;
                end
                ST_READ: begin
                    widx <= widx + 1'b1;
                    if (widx == LAST_WORD) state <= ST_CMP;
                end
                ST_CMP: begin
                    widx  <= '0;
                    state <= bump_corr ? ST_WRITE : ST_NEXT;
                end
                ST_WRITE: begin
                    widx <= widx + 1'b1;
                    if (widx == LAST_WORD) state <= ST_NEXT;
                end
                ST_NEXT: begin
                    if (frame == LAST_FRAME) begin
                        state <= ST_DONE;
                    end else begin
                        frame <= frame + 1'b1;
                        state <= ST_REQ;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Saturating per-sweep counters, cleared when a sweep is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            corr_count   <= '0;
            benign_count <= '0;
        end else begin
            if (bump_corr && corr_count != CNT_MAX)  corr_count   <= corr_count + 1'b1;
            if (bump_ben && benign_count != CNT_MAX) benign_count <= benign_count + 1'b1;
        end
    end

    assign cfg_req    = (state == ST_REQ) || (state == ST_READ) ||
                        (state == ST_CMP) || (state == ST_WRITE);
    assign rd_en      = (state == ST_READ);
    assign wr_en      = (state == ST_WRITE);
    assign gold_rd_en = rd_en && !refresh_mode;
    assign clear      = (state == ST_REQ);
    assign busy       = (state != ST_IDLE);
    assign pass_done  = (state == ST_DONE);

    // R6: no port access without the grant.
    assert_access_granted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en || wr_en) |-> cfg_gnt);

    // R6: the request is still held in the cycle after any read.
    assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> cfg_req);

    // R8: the end-of-sweep pulse lasts one cycle and leaves the block idle.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> (!pass_done && !busy));

    // R9: a refresh sweep never writes configuration memory.
    assert_refresh_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_mode |-> !wr_en);

    // R11: a saturated counter stays saturated until the next sweep.
    assert_no_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_count == CNT_MAX && !accept) |=> (corr_count == CNT_MAX));

    // R2: within a sweep the frame address only steps up by one.
    assert_frame_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && !$stable(frame)) |-> (frame == $past(frame) + 1'b1));

endmodule

// File: rtl/frame_scrubber.sv
// Top of the masked frame scrubber: sequencer, streaming compare, frame buffer.
// Assumes: all three external stores return data one cycle after the address,
// and NUM_FRAMES and FRAME_WORDS are at least 2.
module frame_scrubber #(
    parameter int NUM_FRAMES  = 8,
    parameter int FRAME_WORDS = 93,
    parameter int WORD_W      = 32,
    parameter int LANE_W      = 8,
    parameter int CNT_W       = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic                           refresh,
    output logic                           cfg_req,
    input  logic                           cfg_gnt,
    output logic [$clog2(NUM_FRAMES)-1:0]  scan_frame,
    output logic [$clog2(FRAME_WORDS)-1:0] cfg_word,
    output logic                           cfg_rd_en,
    input  logic [WORD_W-1:0]              cfg_rd_data,
    output logic                           cfg_wr_en,
    output logic [WORD_W-1:0]              cfg_wr_data,
    output logic                           gold_rd_en,
    input  logic [WORD_W-1:0]              gold_rd_data,
    input  logic [WORD_W-1:0]              mask_rd_data,
    output logic                           gold_wr_en,
    output logic [$clog2(FRAME_WORDS)-1:0] gold_wr_word,
    output logic [WORD_W-1:0]              gold_wr_data,
    output logic [CNT_W-1:0]               corr_count,
    output logic [CNT_W-1:0]               benign_count,
    output logic                           busy,
    output logic                           pass_done
);

    localparam int WI_W = $clog2(FRAME_WORDS);

    logic              ess_any, ben_any, refresh_mode, clear;
    logic              buf_we;
    logic [WI_W-1:0]   buf_waddr;
    logic [WORD_W-1:0] buf_wdata;

    scrub_ctrl #(
        .NUM_FRAMES (NUM_FRAMES),
        .FRAME_WORDS(FRAME_WORDS),
        .CNT_W      (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .refresh     (refresh),
        .cfg_gnt     (cfg_gnt),
        .ess_any     (ess_any),
        .ben_any     (ben_any),
        .cfg_req     (cfg_req),
        .frame       (scan_frame),
        .widx        (cfg_word),
        .rd_en       (cfg_rd_en),
        .wr_en       (cfg_wr_en),
        .gold_rd_en  (gold_rd_en),
        .refresh_mode(refresh_mode),
        .clear       (clear),
        .corr_count  (corr_count),
        .benign_count(benign_count),
        .busy        (busy),
        .pass_done   (pass_done)
    );

    scrub_cmp #(
        .WORD_W     (WORD_W),
        .FRAME_WORDS(FRAME_WORDS),
        .LANE_W     (LANE_W)
    ) u_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .refresh_mode(refresh_mode),
        .rd_fire     (cfg_rd_en),
        .rd_word     (cfg_word),
        .cfg_rd_data (cfg_rd_data),
        .gold_rd_data(gold_rd_data),
        .mask_rd_data(mask_rd_data),
        .ess_any     (ess_any),
        .ben_any     (ben_any),
        .buf_we      (buf_we),
        .buf_waddr   (buf_waddr),
        .buf_wdata   (buf_wdata),
        .gold_wr_en  (gold_wr_en),
        .gold_wr_word(gold_wr_word),
        .gold_wr_data(gold_wr_data)
    );

    scrub_frame_buf #(
        .WORD_W     (WORD_W),
        .FRAME_WORDS(FRAME_WORDS)
    ) u_buf (
        .clk  (clk),
        .we   (buf_we),
        .waddr(buf_waddr),
        .wdata(buf_wdata),
        .raddr(cfg_word),
        .rdata(cfg_wr_data)
    );

endmodule

// File: tb/frame_scrubber_bench.sv
// Bench for frame_scrubber: memory models, grant responder, random upsets and
// directed corners, all checked against bench-computed expectations.
module frame_scrubber_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NF    = 8;
    localparam int FW    = 93;
    localparam int W     = 32;
    localparam int CW    = 3;
    localparam int TOTAL = NF * FW;
    localparam int CMAX  = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n, start, refresh, cfg_gnt;
    logic cfg_req, cfg_rd_en, cfg_wr_en, gold_rd_en, gold_wr_en, busy, pass_done;
    logic [$clog2(NF)-1:0] scan_frame;
    logic [$clog2(FW)-1:0] cfg_word, gold_wr_word;
    logic [W-1:0] cfg_rd_data, cfg_wr_data, gold_rd_data, mask_rd_data, gold_wr_data;
    logic [CW-1:0] corr_count, benign_count;

    logic [W-1:0] cfg_mem [TOTAL];
    logic [W-1:0] gold_mem[TOTAL];
    logic [W-1:0] mask_mem[TOTAL];
    logic [W-1:0] exp_mem [TOTAL];

    int errors = 0, checks = 0;
    int hold = 0;
    bit holdoff_en = 1'b0;
    int mon_f = 0, mon_w = 0, ord_err = 0, acc_err = 0, wr_cnt = 0, gwr_cnt = 0, req_falls = 0;
    bit req_prev = 1'b0;
    int exp_corr, exp_ben, exp_cycles;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_scrubber #(.NUM_FRAMES(NF), .FRAME_WORDS(FW), .WORD_W(W), .CNT_W(CW)) u_frame_scrubber (
        .clk(clk), .rst_n(rst_n), .start(start), .refresh(refresh),
        .cfg_req(cfg_req), .cfg_gnt(cfg_gnt), .scan_frame(scan_frame), .cfg_word(cfg_word),
        .cfg_rd_en(cfg_rd_en), .cfg_rd_data(cfg_rd_data), .cfg_wr_en(cfg_wr_en),
        .cfg_wr_data(cfg_wr_data), .gold_rd_en(gold_rd_en), .gold_rd_data(gold_rd_data),
        .mask_rd_data(mask_rd_data), .gold_wr_en(gold_wr_en), .gold_wr_word(gold_wr_word),
        .gold_wr_data(gold_wr_data), .corr_count(corr_count), .benign_count(benign_count),
        .busy(busy), .pass_done(pass_done));

    // Memory models: one-cycle read latency, writes at the edge.
    always @(posedge clk) begin
        if (cfg_rd_en)  cfg_rd_data <= cfg_mem[int'(scan_frame)*FW + int'(cfg_word)];
        if (cfg_wr_en)  cfg_mem[int'(scan_frame)*FW + int'(cfg_word)] <= cfg_wr_data;
        if (gold_rd_en) begin
            gold_rd_data <= gold_mem[int'(scan_frame)*FW + int'(cfg_word)];
            mask_rd_data <= mask_mem[int'(scan_frame)*FW + int'(cfg_word)];
        end
        if (gold_wr_en) gold_mem[int'(scan_frame)*FW + int'(gold_wr_word)] <= gold_wr_data;
    end

    // Grant responder: registered, with optional random hold-off.
    always @(posedge clk) begin
        if (!rst_n || !cfg_req) begin
            cfg_gnt <= 1'b0;
            hold    <= holdoff_en ? int'($urandom % 5) : 0;
        end else if (hold != 0) begin
            hold <= hold - 1;
        end else begin
            cfg_gnt <= 1'b1;
        end
    end

    // Port monitor: read order, grant use, write and request-drop counts.
    always @(negedge clk) begin
        if (rst_n) begin
            if ((cfg_rd_en || cfg_wr_en) && !cfg_gnt) acc_err++;
            if (cfg_rd_en) begin
                if (int'(scan_frame) != mon_f || int'(cfg_word) != mon_w) ord_err++;
                if (mon_w == FW - 1) begin mon_w = 0; mon_f++; end
                else mon_w++;
            end
            if (cfg_wr_en)  wr_cnt++;
            if (gold_wr_en) gwr_cnt++;
            if (req_prev && !cfg_req) req_falls++;
            req_prev = cfg_req;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected counters, image and sweep length from the memory contents.
    task automatic predict(input bit rf);
        exp_corr = 0; exp_ben = 0; exp_cycles = 0;
        for (int f = 0; f < NF; f++) begin
            bit ess = 0, ben = 0;
            for (int w = 0; w < FW; w++) begin
                logic [W-1:0] d = cfg_mem[f*FW+w] ^ gold_mem[f*FW+w];
                if ((d & mask_mem[f*FW+w]) != 0)  ess = 1;
                if ((d & ~mask_mem[f*FW+w]) != 0) ben = 1;
            end
            if (rf) begin ess = 0; ben = 0; end
            for (int w = 0; w < FW; w++)
                exp_mem[f*FW+w] = ess ? gold_mem[f*FW+w] : cfg_mem[f*FW+w];
            if (ess) exp_corr++;
            else if (ben) exp_ben++;
            exp_cycles += 4 + FW + (ess ? FW : 0);
        end
    endtask

    // One sweep with checks; inject pulses start/refresh while busy.
    task automatic run_pass(input string name, input bit rf, input bit timed, input bit inject);
        int cnt = 0, bad = 0, nwr;
        predict(rf);
        nwr = exp_corr * FW;
        mon_f = 0; mon_w = 0; ord_err = 0; acc_err = 0; wr_cnt = 0; gwr_cnt = 0; req_falls = 0;
        @(negedge clk); start = 1'b1; refresh = rf;
        @(negedge clk); start = 1'b0; refresh = 1'b0;
        while (!pass_done && cnt < 5000) begin
            start   = inject && (cnt == 50 || cnt == 200);
            refresh = inject && (cnt == 50 || cnt == 200);
            @(negedge clk); cnt++;
        end
        start = 1'b0; refresh = 1'b0;
        chk({name, " R7 sweep ends"}, int'(cnt < 5000), 1);
        if (timed) chk({name, " R7 sweep length"}, cnt, exp_cycles);
        chk({name, " R3 corr_count"}, int'(corr_count), (exp_corr > CMAX) ? CMAX : exp_corr);
        chk({name, " R4 benign_count"}, int'(benign_count), exp_ben);
        @(negedge clk);
        chk({name, " R8 single pulse"}, int'(pass_done), 0);
        chk({name, " R8 idle after"}, int'(busy), 0);
        for (int i = 0; i < TOTAL; i++) if (cfg_mem[i] !== exp_mem[i]) bad++;
        chk({name, " R3 R4 R5 image"}, bad, 0);
        chk({name, " R3 write count"}, wr_cnt, nwr);
        chk({name, " R2 read order"}, ord_err, 0);
        chk({name, " R2 frames read"}, mon_f, NF);
        chk({name, " R6 access w/o grant"}, acc_err, 0);
        chk({name, " R6 request drops"}, req_falls, NF);
        chk({name, " R9 good writes"}, gwr_cnt, rf ? TOTAL : 0);
    endtask

    // Random upsets: per frame none, significant, non-significant or both.
    task automatic upset_random();
        for (int f = 0; f < NF; f++) begin
            int kind = int'($urandom % 4);
            if (kind == 1 || kind == 3) begin
                int w = int'($urandom % FW); int b = int'($urandom % W);
                mask_mem[f*FW+w][b] = 1'b1; cfg_mem[f*FW+w][b] = ~cfg_mem[f*FW+w][b];
            end
            if (kind == 2 || kind == 3) begin
                int w = int'($urandom % FW); int b = int'($urandom % W);
                if (mask_mem[f*FW+w][b] == 1'b0) cfg_mem[f*FW+w][b] = ~cfg_mem[f*FW+w][b];
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; start = 1'b0; refresh = 1'b0;
        for (int i = 0; i < TOTAL; i++) begin
            gold_mem[i] = $urandom; mask_mem[i] = $urandom; cfg_mem[i] = gold_mem[i];
        end
        repeat (3) @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 pass_done", int'(pass_done), 0);
        chk("R1 cfg_req", int'(cfg_req), 0);
        chk("R1 strobes", int'(cfg_rd_en | cfg_wr_en | gold_wr_en), 0);
        chk("R1 counters", int'(corr_count) + int'(benign_count), 0);
        chk("R1 scan_frame", int'(scan_frame), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_pass("clean R5", 1'b0, 1'b1, 1'b0);

        for (int k = 0; k < 3; k++) begin
            upset_random();
            run_pass("random", 1'b0, 1'b1, 1'b0);
        end

        holdoff_en = 1'b1;
        for (int k = 0; k < 2; k++) begin
            upset_random();
            run_pass("holdoff R6", 1'b0, 1'b0, 1'b0);
        end
        holdoff_en = 1'b0;

        upset_random();
        run_pass("busy start R10", 1'b0, 1'b1, 1'b1);

        // Directed corners: significant flip in the very last word, benign in the first.
        mask_mem[TOTAL-1][W-1] = 1'b1; cfg_mem[TOTAL-1][W-1] = ~cfg_mem[TOTAL-1][W-1];
        mask_mem[0][0] = 1'b0;         cfg_mem[0][0] = ~cfg_mem[0][0];
        run_pass("corner", 1'b0, 1'b1, 1'b0);
        cfg_mem[0][0] = gold_mem[0][0];

        // All frames significant: counter saturates at 2^CW-1.
        for (int f = 0; f < NF; f++) begin
            mask_mem[f*FW+3][5] = 1'b1; cfg_mem[f*FW+3][5] = ~cfg_mem[f*FW+3][5];
        end
        run_pass("saturate R11", 1'b0, 1'b1, 1'b0);
        run_pass("cleared R11", 1'b0, 1'b1, 1'b0);

        // Partial-update stand-in: change memory, refresh, then sweep cleanly.
        upset_random();
        for (int i = 0; i < 40; i++) cfg_mem[$urandom % TOTAL] = $urandom;
        run_pass("refresh R9", 1'b1, 1'b1, 1'b0);
        begin
            int bad = 0;
            for (int i = 0; i < TOTAL; i++) if (gold_mem[i] !== cfg_mem[i]) bad++;
            chk("R9 good store equals memory", bad, 0);
        end
        run_pass("after refresh R9", 1'b0, 1'b1, 1'b0);
        chk("R9 no false differences", int'(corr_count) + int'(benign_count), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule